// File: doc/BRIEF.md
# Shadow Memory Attribute Router

This block holds the seven byte-wide attribute registers that decide how the legacy upper-memory window (0xC0000 to 0xFFFFF) behaves. The window is cut into twelve 16 KB areas from 0xC0000 to 0xEFFFF and one 64 KB area from 0xF0000 to 0xFFFFF. Each area has its own read enable and write enable. When a read enable is set, reads go to the shadow RAM copy. When it is clear, reads are served from ROM. When a write enable is set, writes go to shadow RAM. When it is clear, writes are thrown away.

Firmware programs the registers through a byte-wide configuration port. The memory side of the system presents each request with its 20-bit address and direction. In the same cycle the block answers with a route code and, for ROM reads, the byte address inside a combined ROM image. That image holds the BIOS ROM first and the expansion ROM right after it. Reads in 0xE0000 to 0xFFFFF land in the top 128 KB of the BIOS part. Reads in 0xC0000 to 0xDFFFF land in the expansion part.

When a register write actually changes a stored byte, the block raises a one-cycle pulse. Downstream caches of the mapping can use this pulse to flush.

Top module: `shadow_attr_router`

## Requirements
- R1: After reset every attribute register reads 0x00. Every in-window read then routes to ROM (code 2'b01) and every in-window write is dropped (code 2'b11).
- R2: Register offset 0x59 governs the single area 0xF0000–0xFFFFF: bit 4 is its read enable and bit 5 is its write enable. Its other bits are stored but change no routing.
- R3: Register offsets 0x5A–0x5F each govern two 16 KB areas. The register at offset k covers the lower area starting at 0xC0000 + (k−0x5A)·0x8000, using bit 0 as read enable and bit 1 as write enable. It also covers the upper area 0x4000 above that, using bit 4 as read enable and bit 5 as write enable.
- R4: The area of a request is address bits [17:14], clamped to 12. All four 16 KB slices of 0xF0000–0xFFFFF therefore share the 0x59 enables.
- R5: An in-window read routes to shadow RAM (code 2'b10) when its area read enable is 1, and to ROM (code 2'b01) otherwise.
- R6: An in-window write routes to shadow RAM (code 2'b10) when its area write enable is 1, and is dropped (code 2'b11) otherwise.
- R7: A request whose address bits [19:18] are not 2'b11, or a cycle with no request, gives code 2'b00. romAddr is 0 whenever the code is not ROM.
- R8: A ROM read at 0xE0000–0xFFFFF gives romAddr = BIOS size − 0x20000 + addr[16:0]. With the default 512 KB BIOS this is 0x60000 + addr[16:0].
- R9: A ROM read at 0xC0000–0xDFFFF gives romAddr = BIOS size + addr[16:0]. With the default this is 0x80000 + addr[16:0].
- R10: A configuration write to 0x59–0x5F whose byte differs from the stored byte updates the register and sets mapChanged high for exactly the one cycle after that clock edge. A write of the same byte changes nothing and gives no pulse.
- R11: A configuration read of 0x59–0x5F returns the full stored byte, including unused bits. Other offsets read 0x00, and writes to them affect no register and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration offset for the read and write ports |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Configuration read byte at cfgAddr (combinational) |
| memValid | input | 1 | Memory request present |
| memWrite | input | 1 | 1 = write request, 0 = read request |
| memAddr | input | 20 | Memory request address |
| routeTarget | output | 2 | 00 not in window, 01 ROM, 10 shadow RAM, 11 dropped |
| romAddr | output | BIOS_AW+1 | Byte address in the combined ROM image for ROM reads |
| mapChanged | output | 1 | One-cycle pulse after a register byte changes |

## Verification
The assertions assume that memValid, memWrite and memAddr hold steady around each rising edge. They also assume that a multi-byte configuration write arrives one byte per cycle on cfgWrEn. The route code is combinational, so a glitch at the edge would be sampled. The stimulus changes every input only on the falling edge and issues at most one configuration byte per cycle. This keeps the same-value check on stored bytes meaningful.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int ATTR_REGS  = 7;
  localparam int ATTR_AREAS = 13;
  localparam int MEM_AW     = 20;

  typedef enum logic [1:0] {
    RT_NONE   = 2'b00,
    RT_ROM    = 2'b01,
    RT_SHADOW = 2'b10,
    RT_DROP   = 2'b11
  } route_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [ATTR_REGS-1:0] regSel;
    logic [7:0]           data;
    logic                 commit;
  } attr_strobe_t;
endpackage

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_attr_pkg::*;
#(
  parameter logic [7:0] BASE_OFF = 8'h59,
  parameter int         NUM_REGS = ATTR_REGS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [7:0]   cfgAddr,
  input  logic [7:0]   cfgWrData,
  input  logic [7:0]   curByte,
  output attr_strobe_t strobe,
  output logic         mapChanged
);
  logic [7:0] relOff;
  logic       hit;

  assign relOff = cfgAddr - BASE_OFF;
  assign hit    = (cfgAddr >= BASE_OFF) && (relOff < 8'(NUM_REGS));

  // commit only a byte that differs from what is stored
  always_comb begin
    strobe = '0;
    if (cfgWrEn && hit && (cfgWrData != curByte)) begin
      strobe.regSel = NUM_REGS'(1) << relOff;
      strobe.data   = cfgWrData;
      strobe.commit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mapChanged <= 1'b0;
    else       mapChanged <= strobe.commit;
  end

  assert_pulse_has_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    mapChanged |-> $past(cfgWrEn));

  assert_same_byte_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgWrData == curByte)) |=> !mapChanged);

  assert_foreign_offset_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !hit) |=> !mapChanged);
endmodule

// File: rtl/shadow_attr_path.sv
module shadow_attr_path
  import shadow_attr_pkg::*;
#(
  parameter logic [7:0] BASE_OFF  = 8'h59,
  parameter int         NUM_REGS  = ATTR_REGS,
  parameter int         NUM_AREAS = ATTR_AREAS,
  parameter int         BIOS_AW   = 19,
  localparam int        ROM_AW    = BIOS_AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  attr_strobe_t      strobe,
  input  logic [7:0]        cfgAddr,
  output logic [7:0]        cfgRdData,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [MEM_AW-1:0] memAddr,
  output logic [1:0]        routeTarget,
  output logic [ROM_AW-1:0] romAddr
);
  localparam int SEL_W  = $clog2(NUM_REGS);
  localparam int AIDX_W = 4;
  localparam logic [AIDX_W-1:0] TOP_AREA = AIDX_W'(NUM_AREAS - 1);
  localparam logic [ROM_AW-1:0] BIOS_TAIL = ROM_AW'((1 << BIOS_AW) - (1 << 17));
  localparam logic [ROM_AW-1:0] EXP_BASE  = ROM_AW'(1 << BIOS_AW);

  logic [7:0] attrReg [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                attrReg[r] <= 8'h00;
      else if (strobe.regSel[r]) attrReg[r] <= strobe.data;
    end
  end

  logic [7:0]       relOff;
  logic [SEL_W-1:0] rdIdx;
  assign relOff = cfgAddr - BASE_OFF;
  assign rdIdx  = relOff[SEL_W-1:0];
  assign cfgRdData = ((cfgAddr >= BASE_OFF) && (relOff < 8'(NUM_REGS))) ? attrReg[rdIdx] : 8'h00;

  // per-area enables unpacked from the nibble pairs
  logic [NUM_AREAS-1:0] rdEn, wrEn;
  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    if (a == NUM_AREAS - 1) begin : g_top
      assign rdEn[a] = attrReg[0][4];
      assign wrEn[a] = attrReg[0][5];
    end else begin : g_pair
      assign rdEn[a] = attrReg[1 + a/2][(a%2)*4];
      assign wrEn[a] = attrReg[1 + a/2][(a%2)*4 + 1];
    end
  end

  logic [AIDX_W-1:0] rawIdx, areaIdx;
  logic              inWindow;
  route_e            route;

  assign rawIdx   = memAddr[17:14];
  assign areaIdx  = (rawIdx > TOP_AREA) ? TOP_AREA : rawIdx;
  assign inWindow = (memAddr[19:18] == 2'b11);

  always_comb begin
    if (!memValid || !inWindow) route = RT_NONE;
    else if (memWrite)          route = wrEn[areaIdx] ? RT_SHADOW : RT_DROP;
    else                        route = rdEn[areaIdx] ? RT_SHADOW : RT_ROM;
  end

  always_comb begin
    romAddr = '0;
    if (route == RT_ROM)
      romAddr = (memAddr[17] ? BIOS_TAIL : EXP_BASE) + ROM_AW'(memAddr[16:0]);
  end

  assign routeTarget = route;

  assert_read_never_dropped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && inWindow) |-> (routeTarget == RT_ROM || routeTarget == RT_SHADOW));

  assert_write_never_rom_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && inWindow) |-> (routeTarget == RT_DROP || routeTarget == RT_SHADOW));

  assert_outside_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memValid || memAddr[19:18] != 2'b11) |-> (routeTarget == RT_NONE && romAddr == '0));

  assert_bios_tail_R8: assert property (@(posedge clk) disable iff (!rstN)
    (routeTarget == RT_ROM && memAddr[17]) |-> (romAddr >= BIOS_TAIL && romAddr < EXP_BASE));

  assert_exp_space_R9: assert property (@(posedge clk) disable iff (!rstN)
    (routeTarget == RT_ROM && !memAddr[17]) |-> (romAddr >= EXP_BASE));

  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.commit) |-> $stable(attrReg[0]));
endmodule

// File: rtl/shadow_attr_router.sv
module shadow_attr_router
  import shadow_attr_pkg::*;
#(
  parameter logic [7:0] BASE_OFF  = 8'h59,
  parameter int         NUM_REGS  = ATTR_REGS,
  parameter int         NUM_AREAS = ATTR_AREAS,
  parameter int         BIOS_AW   = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic [MEM_AW-1:0] memAddr,
  output logic [1:0]        routeTarget,
  output logic [BIOS_AW:0]  romAddr,
  output logic              mapChanged
);
  attr_strobe_t strobe;

  shadow_attr_ctrl #(.BASE_OFF(BASE_OFF), .NUM_REGS(NUM_REGS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .curByte(cfgRdData), .strobe(strobe),
    .mapChanged(mapChanged)
  );

  shadow_attr_path #(.BASE_OFF(BASE_OFF), .NUM_REGS(NUM_REGS),
                     .NUM_AREAS(NUM_AREAS), .BIOS_AW(BIOS_AW)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgRdData(cfgRdData), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .routeTarget(routeTarget), .romAddr(romAddr)
  );
endmodule

// File: tb/shadow_attr_router_tb.sv
module shadow_attr_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        memValid = 1'b0;
  logic        memWrite = 1'b0;
  logic [19:0] memAddr = 20'h0;
  logic [1:0]  routeTarget;
  logic [19:0] romAddr;
  logic        mapChanged;

  int checkCount = 0;
  int failCount  = 0;
  logic [7:0] model [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_attr_router dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .routeTarget(routeTarget),
    .romAddr(romAddr), .mapChanged(mapChanged)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected route from the requirement text
  function automatic logic [1:0] expRoute(input logic [19:0] a, input logic wr);
    int area;
    logic re, we;
    if (a[19:18] != 2'b11) return 2'b00;
    area = int'(a[17:14]);
    if (area > 12) area = 12;
    if (area == 12) begin re = model[0][4]; we = model[0][5]; end
    else begin
      re = model[1 + area/2][(area%2)*4];
      we = model[1 + area/2][(area%2)*4 + 1];
    end
    if (wr) return we ? 2'b10 : 2'b11;
    return re ? 2'b10 : 2'b01;
  endfunction

  task automatic memProbe(input string req, input logic [19:0] a, input logic wr,
                          input logic [1:0] expT, input logic [19:0] expRom);
    @(negedge clk);
    memValid = 1'b1; memWrite = wr; memAddr = a;
    #1;
    chk(req, 32'(routeTarget), 32'(expT));
    chk(req, 32'(romAddr), 32'(expRom));
    memValid = 1'b0;
  endtask

  task automatic cfgWrite(input string req, input logic [7:0] off, input logic [7:0] d,
                          input logic expPulse);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = off; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    chk(req, 32'(mapChanged), 32'(expPulse));
    @(posedge clk); #1;
    chk(req, 32'(mapChanged), 32'h0);
    if (off >= 8'h59 && off <= 8'h5F) model[off - 8'h59] = d;
  endtask

  task automatic cfgRead(input string req, input logic [7:0] off, input logic [7:0] exp);
    @(negedge clk);
    cfgAddr = off; #1;
    chk(req, 32'(cfgRdData), 32'(exp));
  endtask

  task automatic testReset();
    for (int k = 0; k < 7; k++) cfgRead("R1 reset reg", 8'(8'h59 + k), 8'h00);
    memProbe("R1 reset read C0000", 20'hC0000, 1'b0, 2'b01, 20'h80000);
    memProbe("R1 reset write F0000", 20'hF0000, 1'b1, 2'b11, 20'h0);
    memProbe("R1 reset read F8000", 20'hF8000, 1'b0, 2'b01, 20'h78000);
  endtask

  task automatic testBypass();
    memProbe("R7 below window", 20'h12345, 1'b0, 2'b00, 20'h0);
    memProbe("R7 A0000 write", 20'hA0000, 1'b1, 2'b00, 20'h0);
    @(negedge clk);
    memValid = 1'b0; memAddr = 20'hC0000; #1;
    chk("R7 no request", 32'(routeTarget), 32'h0);
  endtask

  task automatic testPairs();
    for (int k = 1; k < 7; k++) begin
      logic [19:0] lo, hi;
      lo = 20'hC0000 + 20'(k - 1) * 20'h8000;
      hi = lo + 20'h4000;
      cfgWrite("R3 lower enables", 8'(8'h59 + k), 8'h03, 1'b1);
      memProbe("R3 lower read", lo, 1'b0, 2'b10, 20'h0);
      memProbe("R3 lower write", lo, 1'b1, 2'b10, 20'h0);
      memProbe("R3 upper untouched", hi, 1'b0, expRoute(hi, 1'b0),
               hi[17] ? 20'h60000 + 20'(hi[16:0]) : 20'h80000 + 20'(hi[16:0]));
      cfgWrite("R3 upper enables", 8'(8'h59 + k), 8'h30, 1'b1);
      memProbe("R3 upper read", hi, 1'b0, 2'b10, 20'h0);
      memProbe("R6 upper write", hi + 20'h3FFF, 1'b1, 2'b10, 20'h0);
      memProbe("R6 lower write dropped", lo, 1'b1, 2'b11, 20'h0);
      cfgWrite("R3 clear", 8'(8'h59 + k), 8'h00, 1'b1);
    end
    cfgWrite("R5 read only lower", 8'h5C, 8'h01, 1'b1);
    memProbe("R5 read shadow", 20'hD0010, 1'b0, 2'b10, 20'h0);
    memProbe("R6 write dropped", 20'hD0010, 1'b1, 2'b11, 20'h0);
    cfgWrite("R5 clear", 8'h5C, 8'h00, 1'b1);
  endtask

  task automatic testTopArea();
    cfgWrite("R2 read enable + junk", 8'h59, 8'h1F, 1'b1);
    cfgRead("R11 readback unused bits", 8'h59, 8'h1F);
    for (int s = 0; s < 4; s++) begin
      memProbe("R4 clamped read", 20'hF0000 + 20'(s) * 20'h4000, 1'b0, 2'b10, 20'h0);
      memProbe("R4 clamped write", 20'hF0000 + 20'(s) * 20'h4000 + 20'h10, 1'b1, 2'b11, 20'h0);
    end
    memProbe("R2 junk no effect", 20'hC0000, 1'b0, 2'b01, 20'h80000);
    memProbe("R2 junk no effect EC000", 20'hEC000, 1'b1, 2'b11, 20'h0);
    cfgWrite("R2 write enable", 8'h59, 8'h20, 1'b1);
    memProbe("R2 write shadow", 20'hFFFFF, 1'b1, 2'b10, 20'h0);
    memProbe("R8 read ROM FFFFF", 20'hFFFFF, 1'b0, 2'b01, 20'h7FFFF);
    cfgWrite("R2 clear", 8'h59, 8'h00, 1'b1);
  endtask

  task automatic testTranslate();
    memProbe("R8 E0000", 20'hE0000, 1'b0, 2'b01, 20'h60000);
    memProbe("R8 EFFFF", 20'hEFFFF, 1'b0, 2'b01, 20'h6FFFF);
    memProbe("R9 DFFFF", 20'hDFFFF, 1'b0, 2'b01, 20'h9FFFF);
    memProbe("R9 D1234", 20'hD1234, 1'b0, 2'b01, 20'h91234);
  endtask

  task automatic testChange();
    cfgWrite("R10 first change", 8'h5E, 8'h12, 1'b1);
    cfgWrite("R10 same byte no pulse", 8'h5E, 8'h12, 1'b0);
    cfgRead("R10 value kept", 8'h5E, 8'h12);
    cfgWrite("R10 new byte", 8'h5E, 8'h21, 1'b1);
    cfgRead("R11 readback", 8'h5E, 8'h21);
    cfgWrite("R11 foreign offset", 8'h40, 8'hFF, 1'b0);
    cfgRead("R11 foreign reads zero", 8'h40, 8'h00);
    cfgRead("R11 neighbour untouched", 8'h5F, 8'h00);
    memProbe("R11 routing unchanged", 20'hE8000, 1'b0, 2'b01, 20'h68000);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) model[k] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testBypass();
    testTranslate();
    testPairs();
    testTopArea();
    testChange();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checkCount++; failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule